// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is the master side of a serial peripheral link. One pulse on the start input sends one frame of 4 to 16 bits and receives one frame of the same length. It drives the serial clock, an active-low frame strobe and the transmit data line, and it samples the receive data line. The parallel side takes a transmit word, a size code, a clock divider, and a clock polarity and phase. It returns the received word, a busy level and a one-cycle done pulse.

The frame is built from serial-clock half-periods. Each half-period lasts a whole number of system clock cycles. The phase setting fixes how long the clock rests at its idle level after the strobe falls, and how long it rests again before the strobe rises. The two phases divide this idle time in opposite ways. The polarity sets the idle level. Polarity XOR phase selects which clock edge launches transmit data and which edge captures receive data. Data is sent and received most significant bit first.

Top module: `spi_frame_seq`

## Requirements
- R1: When no frame is in progress, the serial clock rests at the level of the polarity input: low for 0, high for 1.
- R2: With phase 0, the first clock edge comes two half-periods after the strobe falls, and the strobe rises one half-period after the last clock edge.
- R3: With phase 1, the first clock edge comes one half-period after the strobe falls, and the strobe rises two half-periods after the last clock edge.
- R4: When polarity equals phase, transmit data changes only on falling clock edges and receive data is captured on rising edges.
- R5: When polarity differs from phase, transmit data changes only on rising clock edges and receive data is captured on falling edges.
- R6: The frame length N is the 4-bit size code plus one, and codes 0 to 2 give N = 4. A frame has exactly 2N clock edges, sends the low N bits of the transmit word MSB first, and ignores the higher bits.
- R7: The frame strobe goes low on the clock edge that accepts the start pulse and stays low for the whole frame. Busy is high exactly while the strobe is low.
- R8: One half-period lasts divider+1 system clock cycles, so the strobe stays low for (2N+2)*(divider+1) cycles.
- R9: Done is high for exactly one cycle, in the cycle the strobe returns high. From then on, the received word holds the N received bits right-aligned with zeros above them.
- R10: A start pulse that arrives while busy has no effect on the running frame and does not start another frame.
- R11: Polarity, phase, size code and divider are captured when the frame starts. Changes to them during the frame have no effect until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to start a frame |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Clock phase select |
| size_i | input | 4 | Frame length minus one |
| div_i | input | 8 | Half-period length minus one, in system cycles |
| tx_word_i | input | 16 | Word to send, right-aligned |
| rx_word_o | output | 16 | Last received word, right-aligned |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| sclk_o | output | 1 | Serial clock |
| frame_no | output | 1 | Frame strobe, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Every output is registered. The strobe falls on the first rising system edge after start is seen, and all frame timing is counted in system cycles from that edge. The bench samples on falling system edges and starts its cycle count at the first sample that shows the strobe low. It then expects the first clock change at 2H or H, the strobe rise and the done pulse at (2N+2)H, and the last clock change H or 2H before that rise, where H is divider+1. A slave model in the bench launches and captures data on edges chosen from the bench's own record of polarity and phase. The received words on both sides therefore show whether the design used the correct edges.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int unsigned MIN_BITS = 4;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  // size code -> bit count, short codes clamp to MIN_BITS
  function automatic int unsigned frame_bits(input int unsigned code, input int unsigned min_bits);
    return (code < min_bits - 1) ? min_bits : code + 1;
  endfunction
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q == div_i)    cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == div_i);
endmodule

// File: rtl/spi_slot_ctrl.sv
module spi_slot_ctrl
  import spi_seq_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 5,
  parameter int SLOT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [CNT_W-1:0] nbits_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic [DIV_W-1:0] div_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             cap_o,
  output logic             fin_o,
  output logic             sclk_o,
  output logic             frame_no,
  output logic             done_o
);
  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CNT_W-1:0]  nbits_q;
  logic [DIV_W-1:0]  div_q;
  logic              cpol_q, cpha_q;
  logic              sclk_q, frame_q, done_q;

  logic [SLOT_W-1:0] two_n, nxt, lead, k;
  logic              last, in_tog, k_odd, step, skip_shift;

  // frame = lead idle + 2N toggle slots + trail idle, always 2N+2 slots
  assign two_n  = SLOT_W'({nbits_q, 1'b0});
  assign nxt    = slot_q + 1'b1;
  assign last   = (slot_q == two_n + SLOT_W'(1));
  assign lead   = cpha_q ? SLOT_W'(1) : SLOT_W'(2);
  assign k      = nxt - lead;
  assign in_tog = (nxt >= lead) && (k < two_n);
  assign k_odd  = k[0];
  assign step   = (state_q == ST_RUN) && tick_i && !last && in_tog;
  // phase 0 keeps the last bit after its trailing edge; phase 1 presents bit 0 before the first edge
  assign skip_shift = cpha_q ? (k == '0) : (k == two_n - SLOT_W'(1));

  assign cap_o    = step && (k_odd == cpha_q);
  assign shift_o  = step && (k_odd != cpha_q) && !skip_shift;
  assign fin_o    = (state_q == ST_RUN) && tick_i && last;
  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign run_o    = (state_q == ST_RUN);
  assign div_o    = div_q;
  assign sclk_o   = sclk_q;
  assign frame_no = frame_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      nbits_q <= CNT_W'(MIN_BITS);
      div_q   <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      sclk_q  <= 1'b0;
      frame_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sclk_q <= cpol_i;
          if (start_i) begin
            state_q <= ST_RUN;
            slot_q  <= '0;
            nbits_q <= nbits_i;
            div_q   <= div_i;
            cpol_q  <= cpol_i;
            cpha_q  <= cpha_i;
            frame_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tick_i) begin
            if (last) begin
              state_q <= ST_IDLE;
              frame_q <= 1'b1;
              done_q  <= 1'b1;
              sclk_q  <= cpol_q;
            end else begin
              slot_q <= nxt;
              sclk_q <= (in_tog && !k_odd) ? ~cpol_q : cpol_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic              shift_i,
  input  logic              cap_i,
  input  logic              fin_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_word_o
);
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh <= '0;
      rx_sh <= '0;
      rx_q  <= '0;
    end else begin
      if (load_i) begin
        // left-justify so the frame MSB sits at the output bit
        tx_sh <= tx_word_i << (CNT_W'(DATA_W) - nbits_i);
        rx_sh <= '0;
      end else begin
        if (shift_i) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        if (cap_i)   rx_sh <= {rx_sh[DATA_W-2:0], miso_i};
      end
      if (fin_i) rx_q <= rx_sh;
    end
  end

  assign mosi_o    = tx_sh[DATA_W-1];
  assign rx_word_o = rx_q;
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SIZE_W = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W-1:0] tx_word_i,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              frame_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int SLOT_W = $clog2(2 * DATA_W + 3);

  logic [CNT_W-1:0] nbits;
  logic [DIV_W-1:0] div_lat;
  logic             run, tick, load, shift, cap, fin;

  assign nbits = CNT_W'(frame_bits(int'(size_i), MIN_BITS));

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .div_i (div_lat),
    .tick_o(tick)
  );

  spi_slot_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cpol_i  (cpol_i),
    .cpha_i  (cpha_i),
    .nbits_i (nbits),
    .div_i   (div_i),
    .tick_i  (tick),
    .run_o   (run),
    .div_o   (div_lat),
    .load_o  (load),
    .shift_o (shift),
    .cap_o   (cap),
    .fin_o   (fin),
    .sclk_o  (sclk_o),
    .frame_no(frame_no),
    .done_o  (done_o)
  );

  spi_shift_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_path (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .tx_word_i(tx_word_i),
    .nbits_i  (nbits),
    .shift_i  (shift),
    .cap_i    (cap),
    .fin_i    (fin),
    .miso_i   (miso_i),
    .mosi_o   (mosi_o),
    .rx_word_o(rx_word_o)
  );

  assign busy_o = run;
endmodule

// File: rtl/spi_frame_seq_chk.sv
module spi_frame_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpol_i,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic frame_no,
  input logic mosi_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_idle_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !busy_o && $past(!busy_o) |-> sclk_o == $past(cpol_i));

  p_strobe_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !frame_no);

  p_strobe_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> frame_no);

  p_mosi_on_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && busy_o && $past(busy_o) && !$stable(mosi_o) |-> !$stable(sclk_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_at_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(frame_no));
endmodule

bind spi_frame_seq spi_frame_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cpol_i  (cpol_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sclk_o  (sclk_o),
  .frame_no(frame_no),
  .mosi_o  (mosi_o)
);

// File: tb/spi_frame_seq_bench.sv
module spi_frame_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {pol, pha, size, div, tx, slave word}
  localparam logic [45:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'd7,  8'd0, 16'h00A5, 16'h003C},
    {1'b0, 1'b1, 4'd7,  8'd1, 16'hFF96, 16'h00C3},
    {1'b1, 1'b0, 4'd15, 8'd0, 16'hBEEF, 16'h1357},
    {1'b1, 1'b1, 4'd15, 8'd2, 16'h8001, 16'hF00F},
    {1'b0, 1'b0, 4'd3,  8'd1, 16'h000B, 16'h0005},
    {1'b1, 1'b1, 4'd0,  8'd0, 16'h0006, 16'h0009},
    {1'b0, 1'b1, 4'd11, 8'd3, 16'h0ABC, 16'h0DEF},
    {1'b1, 1'b0, 4'd4,  8'd0, 16'h001F, 16'h0015}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [3:0] size = 4'd7;
  logic [7:0] div = 8'd0;
  logic [15:0] tx = '0, rx_word;
  logic busy, done, sclk, frame_n, mosi;
  logic miso = 1'b0;

  int checks = 0, failures = 0;

  // slave model state
  logic sl_pol = 1'b0, sl_pha = 1'b0;
  logic [15:0] sl_word = '0, sl_rx = '0;
  int sl_n = 4, sl_idx = 0, edge_cnt = 0;
  logic fr_prev = 1'b1, sc_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_seq u_spi_frame_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cpol_i(cpol), .cpha_i(cpha),
    .size_i(size), .div_i(div), .tx_word_i(tx), .rx_word_o(rx_word),
    .busy_o(busy), .done_o(done), .sclk_o(sclk), .frame_no(frame_n),
    .mosi_o(mosi), .miso_i(miso)
  );

  always @(frame_n or sclk) begin
    if (fr_prev === 1'b1 && frame_n === 1'b0) begin
      sl_rx = '0;
      edge_cnt = 0;
      if (!sl_pha) begin sl_idx = sl_n - 1; miso = sl_word[sl_idx]; end
      else sl_idx = sl_n;
    end else if (frame_n === 1'b0 && sclk !== sc_prev) begin
      edge_cnt++;
      if ((sl_pol == sl_pha) ? (sclk == 1'b0) : (sclk == 1'b1)) begin
        if (sl_idx > 0) begin sl_idx--; miso = sl_word[sl_idx]; end
      end else begin
        sl_rx = {sl_rx[14:0], mosi};
      end
    end
    fr_prev = frame_n;
    sc_prev = sclk;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_frame(input logic pol, input logic pha, input logic [3:0] sz, input logic [7:0] dv,
                          input logic [15:0] txw, input logic [15:0] sw, input bit disturb);
    int n, h, lead, trail, c, first, last_edge, rise, lim;
    logic prev, done_at_rise;
    logic [15:0] mask;
    string rq;
    n = (sz < 3) ? 4 : int'(sz) + 1;
    h = int'(dv) + 1;
    lead = pha ? 1 : 2;
    trail = pha ? 2 : 1;
    mask = 16'((32'd1 << n) - 1);
    rq = (pol == pha) ? "R4" : "R5";
    sl_pol = pol; sl_pha = pha; sl_n = n; sl_word = sw;
    @(negedge clk);
    cpol = pol; cpha = pha; size = sz; div = dv; tx = txw;
    repeat (3) @(negedge clk);
    chk(sclk == pol, "R1", "idle sclk", sclk, pol);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(frame_n == 1'b0 && busy == 1'b1, "R7", "strobe low+busy after start", {frame_n, busy}, 2'b01);
    c = 0; first = -1; last_edge = -1; rise = -1; prev = sclk; done_at_rise = 1'b0;
    lim = 40 * h + 10;
    while (c < lim) begin
      if (sclk !== prev) begin
        if (first < 0) first = c;
        last_edge = c;
        prev = sclk;
      end
      if (frame_n) begin
        rise = c;
        done_at_rise = done;
        break;
      end
      if (disturb && c == 3 * h) begin
        start = 1'b1; tx = 16'h5A5A; cpol = ~pol; cpha = ~pha;
        size = 4'd15; div = dv + 8'd2;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    chk(rise == (2 * n + 2) * h, "R8", "strobe low length", rise, (2 * n + 2) * h);
    chk(first == lead * h, pha ? "R3" : "R2", "lead-in", first, lead * h);
    chk(rise - last_edge == trail * h, pha ? "R3" : "R2", "lead-out", rise - last_edge, trail * h);
    chk(edge_cnt == 2 * n, "R6", "edge count", edge_cnt, 2 * n);
    chk(done_at_rise == 1'b1, "R9", "done at strobe rise", done_at_rise, 1);
    chk(rx_word == (sw & mask), rq, "received word", rx_word, sw & mask);
    chk(sl_rx == (txw & mask), rq, "slave captured MSB first R6", sl_rx, txw & mask);
    if (disturb) chk(rise == (2 * n + 2) * h && sl_rx == (txw & mask), "R11", "settings held", sl_rx, txw & mask);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9", "done one cycle", {done, busy}, 0);
    if (disturb) begin
      for (int i = 0; i < 30; i++) begin
        if (!frame_n) break;
        @(negedge clk);
      end
      chk(frame_n == 1'b1 && busy == 1'b0, "R10", "no frame from busy start", {frame_n, busy}, 2'b10);
      chk(sclk == ~pol, "R1", "idle follows new polarity", sclk, ~pol);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R7 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(frame_n == 1'b1, "R7", "reset strobe high", frame_n, 1);
    chk(busy == 1'b0 && done == 1'b0, "R9", "reset busy/done low", {busy, done}, 0);
    chk(rx_word == 16'h0, "R9", "reset rx word", rx_word, 0);
    chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      do_frame(VEC[i][45], VEC[i][44], VEC[i][43:40], VEC[i][39:32], VEC[i][31:16], VEC[i][15:0], 1'b0);
    end

    // corner cases: start while busy and mid-frame setting changes (R10, R11)
    do_frame(1'b0, 1'b0, 4'd7, 8'd1, 16'h00C9, 16'h0036, 1'b1);
    do_frame(1'b1, 1'b1, 4'd5, 8'd0, 16'h002D, 16'h0012, 1'b1);
    // size code 2 clamps to 4 bits, high tx bits ignored (R6)
    do_frame(1'b0, 1'b1, 4'd2, 8'd0, 16'hFFF3, 16'h000A, 1'b0);
    // back-to-back idle polarity change (R1)
    @(negedge clk); cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1 && frame_n == 1'b1, "R1", "idle high", sclk, 1);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R1", "idle low", sclk, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule